// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. When it is enabled and the transmit queue reports a word waiting, it pops that word, shifts it out MSB first on `mosi` while sampling `miso`, and hands the received word to the receive queue with a one-cycle push strobe. The serial clock comes from the module clock through a programmable half-period divider. One reserved divider code skips the divider altogether, so that every module clock carries one full bit.

Each word is configured when it starts. The settings are the clock idle level and phase, a word length of 4 to 32 bits, the divider, and a late-capture option that moves the sampling point one serial-clock edge later. These settings are latched when the word is popped, so changing them during a word has no effect on it. A static decoder drives three active-low chip selects from a select field. `busy` is high while a word is in flight.

Top module: `spi_master_engine`

## Requirements
- R1: The word length is `cfg_len_m1 + 1` (field values 3 to 31, giving 4 to 32 bits). The received word appears right-aligned on `rx_data` and every bit above the word length is zero.
- R2: Data is sent MSB first. Bit `L-1` of `tx_data` is the first bit on `mosi`, and only the low `L` bits of `tx_data` are sent.
- R3: `cfg_mode[1]` is the idle level of `sclk` and `cfg_mode[0]` selects the phase. With phase 0, data is sampled on the first, third, … edge and launched on the others. With phase 1, data is launched on the first edge and sampled on the second, fourth, … edges. Outside the bypass code a word makes exactly `2L` `sclk` edges, and `sclk` rests at the idle level when `busy` is low.
- R4: For a divider value `D` other than all-ones, each `sclk` half-period lasts `D+1` module clocks and `busy` stays high for `(2L + P)·(D+1)` cycles. `P` is 1 when phase 1 and late capture are both set, and 0 otherwise.
- R5: The all-ones divider code (0x7F) sends one bit per module clock. `busy` stays high for `L + late` cycles, and `miso` is registered at the module-clock rising edge that closes each bit.
- R6: With `cfg_late` set, each sample is taken one edge later. With phase 1 this adds a trailing half-period without an `sclk` edge. In bypass it delays each sample by one clock, so with `miso` looped back to `mosi` the received word is `tx` shifted left by one with the last bit repeated.
- R7: `cs_n[i]` is low exactly when `cfg_cs_sel` equals `1<<i` (values 1, 2, 4). Value 0 and every other value leave all three high.
- R8: A word starts only when `enable` and `tx_valid` are both high and the engine is idle. `tx_pop` is high for that single cycle, and `busy` rises on the next cycle.
- R9: `rx_push` is a one-cycle pulse in the cycle after the last sampling edge of the word. `rx_data` holds the full word during the pulse.
- R10: A slave that launches and samples on the edges given in R3 exchanges words correctly in all four modes, with or without late capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| enable | input | 1 | Allows new words to start |
| cfg_mode | input | 2 | Bit 1 idle level of sclk, bit 0 clock phase |
| cfg_len_m1 | input | 5 | Word length minus one |
| cfg_div | input | 7 | Half-period divider; all-ones selects bypass |
| cfg_late | input | 1 | Sample one edge later |
| cfg_cs_sel | input | 3 | Chip-select code |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 32 | Word at the head of the transmit queue |
| tx_pop | output | 1 | Takes the head word from the transmit queue |
| rx_push | output | 1 | Writes `rx_data` into the receive queue |
| rx_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 3 | Active-low chip selects |
| busy | output | 1 | A word is in flight |

## Verification
Random words are sent with random mode, length, divider and late setting against a behavioural slave that shifts on real `sclk` edges. Comparing the slave's captured word with the transmit word separates bit-order and launch-edge faults. Comparing the received word with the slave's word separates sampling-edge faults. Counting `sclk` edges and busy cycles separates divider and half-period faults from data faults. Bypass words use a `miso`-to-`mosi` loopback, where the late setting changes the data itself. Directed cases cover the 4-bit and 32-bit lengths, divider 0, every chip-select code including invalid ones, and a held-off start with `enable` low.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } eng_state_t;
endpackage

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             bypass,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (bypass || (cnt_q == div));
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: two ticks are at least div+1 cycles apart outside bypass
  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bypass && (div != '0) && $past(tick)) |-> !tick);
endmodule

// File: rtl/spi_eng_csdec.sv
module spi_eng_csdec #(
  parameter int CS_N = 3
) (
  input  logic [CS_N-1:0] sel,
  output logic [CS_N-1:0] cs_n
);
  for (genvar i = 0; i < CS_N; i++) begin : g_cs
    assign cs_n[i] = (sel != CS_N'(1 << i));
  end
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 7,
  parameter int CS_N   = 3,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        cfg_mode,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_late,
  input  logic [CS_N-1:0]   cfg_cs_sel,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_N-1:0]   cs_n,
  output logic              busy
);
  localparam int SLOT_W = LEN_W + 2;
  localparam logic [DIV_W-1:0] BYPASS_CODE = '1;

  eng_state_t        state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              sclk_q, sclk_d, act_q, act_d, push_q, push_d;
  logic [DATA_W-1:0] tx_sh_q, tx_sh_d, rx_sh_q, rx_sh_d;
  logic              cpol_q, cpha_q, late_q, byp_q;
  logic [LEN_W-1:0]  len_q;
  logic [DIV_W-1:0]  div_q;
  logic              start, tick, do_shift, do_samp;
  logic [SLOT_W-1:0] len_full, two_l, last_slot, end_slot;

  spi_eng_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_RUN),
    .bypass(byp_q), .div(div_q), .tick(tick)
  );

  spi_eng_csdec #(.CS_N(CS_N)) u_csdec (.sel(cfg_cs_sel), .cs_n(cs_n));

  always_comb begin
    start    = (state_q == ST_IDLE) && enable && tx_valid;
    len_full = SLOT_W'(len_q) + SLOT_W'(1);
    two_l    = len_full << 1;
    if (byp_q) begin
      last_slot = len_full - SLOT_W'(1) + SLOT_W'(late_q);
      end_slot  = last_slot;
    end else begin
      last_slot = two_l - SLOT_W'(2) + SLOT_W'(cpha_q) + SLOT_W'(late_q);
      end_slot  = two_l - SLOT_W'(1) + SLOT_W'(cpha_q & late_q);
    end
    do_shift = 1'b0;
    do_samp  = 1'b0;
    if (state_q == ST_RUN && tick) begin
      if (byp_q) begin
        do_shift = slot_q < len_full - SLOT_W'(1);
        do_samp  = (slot_q >= SLOT_W'(late_q)) && (slot_q <= last_slot);
      end else begin
        do_shift = (slot_q != '0) && (slot_q[0] != cpha_q) && (slot_q < two_l);
        do_samp  = (slot_q[0] == (cpha_q ^ late_q)) &&
                   (slot_q >= SLOT_W'(late_q)) && (slot_q <= last_slot);
      end
    end
  end

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    sclk_d  = sclk_q;
    act_d   = act_q;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    push_d  = 1'b0;
    if (start) begin
      state_d = ST_RUN;
      slot_d  = '0;
      sclk_d  = cfg_mode[1];
      act_d   = 1'b1;
      tx_sh_d = tx_data << (DATA_W - 1 - int'(cfg_len_m1));
      rx_sh_d = '0;
    end else if (state_q == ST_RUN && tick) begin
      slot_d = slot_q + SLOT_W'(1);
      if (!byp_q && slot_q < two_l) sclk_d = ~sclk_q;
      if (byp_q && slot_q == len_full - SLOT_W'(1)) act_d = 1'b0;
      if (do_shift) tx_sh_d = tx_sh_q << 1;
      if (do_samp)  rx_sh_d = {rx_sh_q[DATA_W-2:0], miso};
      push_d = do_samp && (slot_q == last_slot);
      if (slot_q == end_slot) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      sclk_q  <= 1'b0;
      act_q   <= 1'b0;
      push_q  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      sclk_q  <= sclk_d;
      act_q   <= act_d;
      push_q  <= push_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
    end
  end

  // word settings, loaded only when a word is popped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      late_q <= 1'b0;
      byp_q  <= 1'b0;
      len_q  <= '0;
      div_q  <= '0;
    end else if (start) begin
      cpol_q <= cfg_mode[1];
      cpha_q <= cfg_mode[0];
      late_q <= cfg_late;
      byp_q  <= (cfg_div == BYPASS_CODE);
      len_q  <= cfg_len_m1;
      div_q  <= cfg_div;
    end
  end

  assign tx_pop  = start;
  assign busy    = (state_q == ST_RUN);
  assign mosi    = tx_sh_q[DATA_W-1];
  assign rx_data = rx_sh_q;
  assign rx_push = push_q;
  assign sclk    = byp_q ? (cpol_q ^ (act_q & (cpha_q ? clk : ~clk))) : sclk_q;

  assert_pop_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> busy);
  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(mosi));
  assert_push_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !byp_q) |-> (sclk == cpol_q));
endmodule

// File: tb/test_spi_master_engine.sv
`timescale 1ns/1ps
module test_spi_master_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, cfg_late, tx_valid, miso;
  logic [1:0]  cfg_mode;
  logic [4:0]  cfg_len_m1;
  logic [6:0]  cfg_div;
  logic [2:0]  cfg_cs_sel;
  logic [31:0] tx_data, rx_data;
  logic        tx_pop, rx_push, sclk, mosi, busy;
  logic [2:0]  cs_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural slave
  int          e_cnt = 0;
  int          s_len = 8;
  bit          s_cpha = 1'b0;
  bit          loop = 1'b0;
  logic [31:0] s_word = '0;
  logic [31:0] s_rx = '0;
  logic        slave_bit;

  always #10 clk = ~clk;

  spi_master_engine i_spi_master_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_mode(cfg_mode),
    .cfg_len_m1(cfg_len_m1), .cfg_div(cfg_div), .cfg_late(cfg_late),
    .cfg_cs_sel(cfg_cs_sel), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy)
  );

  function automatic int bit_idx(int e, bit cpha);
    if (!cpha) return e / 2;
    return (e == 0) ? 0 : (e - 1) / 2;
  endfunction

  always_comb begin
    int j;
    j = bit_idx(e_cnt, s_cpha);
    slave_bit = (j < s_len) ? s_word[s_len-1-j] : 1'b0;
  end
  assign miso = loop ? mosi : slave_bit;

  always @(sclk) begin
    if ((e_cnt % 2) == (s_cpha ? 1 : 0)) s_rx = {s_rx[30:0], mosi};
    e_cnt = e_cnt + 1;
  end

  function automatic logic [31:0] len_mask(int len);
    return 32'((64'd1 << len) - 64'd1);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_word(logic [1:0] mode, int len, logic [6:0] div, bit late,
                          logic [31:0] tx, logic [31:0] sw);
    int busy_cyc = 0;
    int guard = 0;
    bit pushed = 1'b0;
    bit byp;
    logic [31:0] got = '0;
    logic [31:0] exp_rx;
    int exp_busy;
    byp = (div == 7'h7F);
    @(negedge clk);
    cfg_mode = mode; cfg_len_m1 = 5'(len - 1); cfg_div = div; cfg_late = late;
    tx_data = tx; s_word = sw; s_len = len; s_cpha = mode[0]; loop = byp;
    enable = 1'b1; tx_valid = 1'b1;
    #1;
    chk(tx_pop == 1'b1, "R8 pop", 32'(tx_pop), 32'd1);
    @(negedge clk);
    tx_valid = 1'b0;
    e_cnt = 0; s_rx = '0;
    while ((busy || !pushed) && guard < 2000) begin
      if (busy) busy_cyc++;
      if (rx_push) begin
        if (pushed) chk(1'b0, "R9 double push", 32'd1, 32'd0);
        pushed = 1'b1; got = rx_data;
      end
      guard++;
      @(negedge clk);
    end
    chk(rx_push == 1'b0, "R9 pulse", 32'(rx_push), 32'd0);
    if (byp) begin
      exp_rx   = late ? (((tx << 1) | (tx & 32'd1)) & len_mask(len)) : (tx & len_mask(len));
      exp_busy = len + int'(late);
      chk(got == exp_rx, "R5 R6 bypass rx", got, exp_rx);
      chk(busy_cyc == exp_busy, "R5 bypass busy", 32'(busy_cyc), 32'(exp_busy));
    end else begin
      exp_rx   = sw & len_mask(len);
      exp_busy = (2*len + int'(mode[0] & late)) * (int'(div) + 1);
      chk(got == exp_rx, "R1 R10 rx word", got, exp_rx);
      chk((s_rx & len_mask(len)) == (tx & len_mask(len)), "R2 msb first",
          s_rx & len_mask(len), tx & len_mask(len));
      chk(busy_cyc == exp_busy, "R4 R6 busy length", 32'(busy_cyc), 32'(exp_busy));
      chk(e_cnt == 2*len, "R3 edge count", 32'(e_cnt), 32'(2*len));
      chk(sclk == mode[1], "R3 idle level", 32'(sclk), 32'(mode[1]));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; enable = 1'b0; tx_valid = 1'b0; cfg_mode = '0; cfg_len_m1 = 5'd7;
    cfg_div = '0; cfg_late = 1'b0; cfg_cs_sel = '0; tx_data = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && rx_push == 1'b0 && sclk == 1'b0, "R9 reset state",
        {29'd0, busy, rx_push, sclk}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: held off while enable is low
    tx_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(tx_pop == 1'b0 && busy == 1'b0, "R8 enable low", {30'd0, tx_pop, busy}, 32'd0);
    end
    tx_valid = 1'b0;

    // R7: chip-select decode over all codes
    for (int c = 0; c < 8; c++) begin
      logic [2:0] exp_cs;
      cfg_cs_sel = 3'(c);
      exp_cs = (c == 1) ? 3'b110 : (c == 2) ? 3'b101 : (c == 4) ? 3'b011 : 3'b111;
      #1;
      chk(cs_n == exp_cs, "R7 cs decode", 32'(cs_n), 32'(exp_cs));
    end

    // directed corners: every mode, both late settings, 4 and 32 bits, div 0
    for (int m = 0; m < 4; m++) begin
      for (int lt = 0; lt < 2; lt++) begin
        run_word(2'(m), 4, 7'd0, 1'(lt), 32'hFFFF_FFF9, 32'h0000_0006);
        run_word(2'(m), 32, 7'd1, 1'(lt), 32'hA5C3_1E70, 32'h3C96_0F5A);
      end
    end
    run_word(2'd0, 4, 7'h7F, 1'b0, 32'h0000_000B, 32'd0);
    run_word(2'd3, 32, 7'h7F, 1'b1, 32'hC001_D00D, 32'd0);
    run_word(2'd1, 9, 7'h7F, 1'b1, 32'h0000_0155, 32'd0);

    // constrained random words
    for (int n = 0; n < 60; n++) begin
      logic [6:0] dv;
      dv = ($urandom_range(0, 3) == 0) ? 7'h7F : 7'($urandom_range(0, 3));
      run_word(2'($urandom_range(0, 3)), $urandom_range(4, 32), dv,
               1'($urandom_range(0, 1)), $urandom, $urandom);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule